// File: doc/BRIEF.md
# Vector Loop Sequencer with Early Exit

The sequencer runs one scalar add-immediate operation across a run of consecutive register elements, one element per clock cycle. A start pulse captures the element count, the source and destination base registers, a signed immediate and a mode word. For element i it reads source register `src_base + i` through an external read port, adds the sign-extended immediate, writes the sum to destination register `dst_base + i` through an external write port, and records one condition bit for that element.

The condition bit tests the sum just produced. It is either "sum is zero" or "sum is negative" (top bit set), and either test can be inverted. When early-exit mode is on, the first element whose condition bit is 0 still has its sum written. The loop then ends at once and the reported vector length becomes that element's index. When early-exit mode is off, every element is processed and the reported length equals the requested one.

The register file is outside the block. Its read port has one cycle of latency, as a synchronous block RAM does. The end of a loop is signalled by a one-cycle done pulse, which comes with the final length and the condition bit vector.

Top module: `vloop_seq`

## Requirements
- R1: Elements are handled strictly in ascending order. The reads go to `src_base+0, +1, ...` on consecutive cycles. A full run of N elements raises done N+1 clock edges after the edge that accepts start.
- R2: Element i writes `rf_rd_data + sext(imm_i)` to register `dst_base + i`. The immediate is IMM_W bits wide and is sign-extended to DATA_W.
- R3: The condition bit of element i is stored in `cond_bits_o[i]`. When `test_sel_i`=0 the raw test is "sum == 0". When `test_sel_i`=1 the raw test is "sum[DATA_W-1] == 1". The raw test is XORed with `test_inv_i`. A bit value of 0 means the element failed.
- R4: With `ff_en_i`=1, the first element i whose condition bit is 0 sets `vlen_o` to i. No later element is written, and done rises i+2 edges after the accepting edge.
- R5: The element that fails in early-exit mode is still written. Such a run makes exactly i+1 writes.
- R6: With `ff_en_i`=0, all elements are written whatever their condition bits are, and `vlen_o` equals the requested length.
- R7: `done_o` is high for exactly one cycle per run. `vlen_o` and `cond_bits_o` hold the run's results while it is high.
- R8: A requested length of 0 raises done in the cycle right after the accepting edge, with `vlen_o`=0 and no register write.
- R9: When done is high, every bit of `cond_bits_o` at an index at or above `vlen_o` reads 0.
- R10: A start pulse that arrives while a run is in progress is ignored, and the run finishes with its original operands.
- R11: A requested length above MAX_VL is treated as MAX_VL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch pulse, accepted when idle |
| vlen_i | input | VL_W | Requested element count |
| dst_base_i | input | REG_AW | First destination register |
| src_base_i | input | REG_AW | First source register |
| imm_i | input | IMM_W | Signed immediate addend |
| ff_en_i | input | 1 | Early-exit mode enable |
| test_sel_i | input | 1 | 0: zero test, 1: negative test |
| test_inv_i | input | 1 | Invert the condition test |
| rf_rd_en_o | output | 1 | Register read strobe |
| rf_rd_addr_o | output | REG_AW | Register read index |
| rf_rd_data_i | input | DATA_W | Read data, valid one cycle after the strobe |
| rf_wr_en_o | output | 1 | Register write strobe |
| rf_wr_addr_o | output | REG_AW | Register write index |
| rf_wr_data_o | output | DATA_W | Register write data |
| done_o | output | 1 | One-cycle end-of-loop pulse |
| vlen_o | output | VL_W | Final vector length |
| cond_bits_o | output | MAX_VL | Per-element condition bits |

## Verification
The bench targets the cut-off point of early exit. It checks a failure at element 0, a failure in the middle and a failure at the last element. A design that drops the failing write would show one write too few, and one that stops a cycle late would write an extra register or report the wrong length. A run with early exit off contains failing elements, which catches a design that truncates when it should not. Further runs cover a zero length, a length at MAX_VL, a length above MAX_VL and a negative immediate, which expose a missing clamp, a broken sign extension or a spurious write. A start pulse with other operands is injected in the middle of a run; a design that reloads on it would write to the wrong registers.

// File: rtl/vloop_pkg.sv
package vloop_pkg;

  typedef enum logic {
    TEST_ZERO = 1'b0,
    TEST_NEG  = 1'b1
  } test_kind_e;

  typedef struct packed {
    logic       ff_en;
    test_kind_e kind;
    logic       invert;
  } loop_mode_t;

endpackage

// File: rtl/vloop_cond.sv
module vloop_cond
  import vloop_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] value,
  input  test_kind_e        kind,
  input  logic              invert,
  output logic              pass
);

  logic raw;

  always_comb begin
    if (kind == TEST_NEG) raw = value[DATA_W-1];
    else                  raw = (value == '0);
    pass = raw ^ invert;
  end

endmodule

// File: rtl/vloop_issue.sv
module vloop_issue #(
  parameter int REG_AW = 7,
  parameter int VL_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic [REG_AW-1:0] base,
  input  logic [VL_W-1:0]   count,
  input  logic              kill,
  output logic              rd_en,
  output logic [REG_AW-1:0] rd_addr,
  output logic [VL_W-1:0]   rd_idx
);

  logic [VL_W-1:0] last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en   <= 1'b0;
      rd_addr <= '0;
      rd_idx  <= '0;
      last_q  <= '0;
    end else if (launch) begin
      rd_en   <= 1'b1;
      rd_addr <= base;
      rd_idx  <= '0;
      last_q  <= count - 1'b1;
    end else if (rd_en) begin
      if (kill || rd_idx == last_q) begin
        rd_en <= 1'b0;
      end else begin
        rd_idx  <= rd_idx + 1'b1;
        rd_addr <= rd_addr + 1'b1;
      end
    end
  end

  // R1: reads continue to the next register in ascending order
  a_r1_ascending: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !kill && !launch && rd_idx != last_q) |=>
      (rd_en && rd_addr == REG_AW'($past(rd_addr) + 1'b1)));

endmodule

// File: rtl/vloop_flags.sv
module vloop_flags #(
  parameter int MAX_VL = 16,
  parameter int VL_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              set,
  input  logic [VL_W-1:0]   idx,
  input  logic              val,
  output logic [MAX_VL-1:0] bits
);

  for (genvar g = 0; g < MAX_VL; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || clear)                   bits[g] <= 1'b0;
      else if (set && idx == VL_W'(g))    bits[g] <= val;
    end
  end

endmodule

// File: rtl/vloop_seq.sv
module vloop_seq
  import vloop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int REG_AW = 7,
  parameter int MAX_VL = 16,
  localparam int VL_W  = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [VL_W-1:0]   vlen_i,
  input  logic [REG_AW-1:0] dst_base_i,
  input  logic [REG_AW-1:0] src_base_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              ff_en_i,
  input  logic              test_sel_i,
  input  logic              test_inv_i,
  output logic              rf_rd_en_o,
  output logic [REG_AW-1:0] rf_rd_addr_o,
  input  logic [DATA_W-1:0] rf_rd_data_i,
  output logic              rf_wr_en_o,
  output logic [REG_AW-1:0] rf_wr_addr_o,
  output logic [DATA_W-1:0] rf_wr_data_o,
  output logic              done_o,
  output logic [VL_W-1:0]   vlen_o,
  output logic [MAX_VL-1:0] cond_bits_o
);

  localparam logic [VL_W-1:0] VL_CAP = VL_W'(MAX_VL);

  logic              busy_q;
  logic [VL_W-1:0]   vl_q;
  logic [REG_AW-1:0] dst_q;
  logic [DATA_W-1:0] imm_q;
  loop_mode_t        mode_q;
  logic              ex_valid_q;
  logic [VL_W-1:0]   ex_idx_q;

  logic [VL_W-1:0]   vl_eff;
  logic              accept;
  logic              launch;
  logic [DATA_W-1:0] sum;
  logic              pass;
  logic              fail_stop;
  logic              last_elem;
  logic [VL_W-1:0]   rd_idx;

  always_comb begin
    vl_eff    = (vlen_i > VL_CAP) ? VL_CAP : vlen_i;
    accept    = start_i && !busy_q;
    launch    = accept && (vl_eff != '0);
    sum       = rf_rd_data_i + imm_q;
    fail_stop = ex_valid_q && mode_q.ff_en && !pass;
    last_elem = (ex_idx_q == vl_q - 1'b1);
  end

  vloop_issue #(.REG_AW(REG_AW), .VL_W(VL_W)) u_issue (
    .clk     (clk),
    .rst     (rst),
    .launch  (launch),
    .base    (src_base_i),
    .count   (vl_eff),
    .kill    (fail_stop),
    .rd_en   (rf_rd_en_o),
    .rd_addr (rf_rd_addr_o),
    .rd_idx  (rd_idx)
  );

  vloop_cond #(.DATA_W(DATA_W)) u_cond (
    .value  (sum),
    .kind   (mode_q.kind),
    .invert (mode_q.invert),
    .pass   (pass)
  );

  vloop_flags #(.MAX_VL(MAX_VL), .VL_W(VL_W)) u_flags (
    .clk   (clk),
    .rst   (rst),
    .clear (accept),
    .set   (ex_valid_q),
    .idx   (ex_idx_q),
    .val   (pass),
    .bits  (cond_bits_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q       <= 1'b0;
      vl_q         <= '0;
      dst_q        <= '0;
      imm_q        <= '0;
      mode_q       <= '0;
      ex_valid_q   <= 1'b0;
      ex_idx_q     <= '0;
      rf_wr_en_o   <= 1'b0;
      rf_wr_addr_o <= '0;
      rf_wr_data_o <= '0;
      done_o       <= 1'b0;
      vlen_o       <= '0;
    end else begin
      done_o     <= 1'b0;
      rf_wr_en_o <= 1'b0;
      ex_valid_q <= rf_rd_en_o && !fail_stop;
      ex_idx_q   <= rd_idx;
      if (accept) begin
        vl_q   <= vl_eff;
        dst_q  <= dst_base_i;
        imm_q  <= {{(DATA_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
        mode_q <= '{ff_en: ff_en_i, kind: test_kind_e'(test_sel_i), invert: test_inv_i};
        if (vl_eff == '0) begin
          done_o <= 1'b1;
          vlen_o <= '0;
        end else begin
          busy_q <= 1'b1;
        end
      end
      if (ex_valid_q) begin
        rf_wr_en_o   <= 1'b1;
        rf_wr_addr_o <= dst_q + REG_AW'(ex_idx_q);
        rf_wr_data_o <= sum;
        if (fail_stop) begin
          done_o <= 1'b1;
          vlen_o <= ex_idx_q;
          busy_q <= 1'b0;
        end else if (last_elem) begin
          done_o <= 1'b1;
          vlen_o <= vl_q;
          busy_q <= 1'b0;
        end
      end
    end
  end

  // R4: a failing element in early-exit mode ends the run at its index
  a_r4_cut: assert property (@(posedge clk) disable iff (rst)
    (ex_valid_q && mode_q.ff_en && !pass) |=> (done_o && vlen_o == $past(ex_idx_q)));

  // R5: the failing element is still written
  a_r5_fail_written: assert property (@(posedge clk) disable iff (rst)
    (ex_valid_q && mode_q.ff_en && !pass) |=> rf_wr_en_o);

  // R6: without early exit the reported length is the requested one
  a_r6_full_len: assert property (@(posedge clk) disable iff (rst)
    (done_o && !mode_q.ff_en) |-> (vlen_o == vl_q));

  // R7: done is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> !done_o);

  // R8: zero length completes at once with no write
  a_r8_zero_len: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_q && vl_eff == '0) |=> (done_o && vlen_o == '0 && !rf_wr_en_o));

  // R9: condition bits at or beyond the final length are zero
  a_r9_tail_zero: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ((cond_bits_o >> vlen_o) == '0));

  // R10: operands stay put while a run is in progress
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start_i) |=> ($stable(vl_q) && $stable(dst_q) && $stable(imm_q)));

  // R11: the captured length never exceeds the maximum
  a_r11_clamp: assert property (@(posedge clk) disable iff (rst)
    vl_q <= VL_CAP);

endmodule

// File: tb/vloop_seq_bench.sv
module vloop_seq_bench;

  localparam int DATA_W = 32;
  localparam int IMM_W  = 16;
  localparam int REG_AW = 7;
  localparam int MAX_VL = 16;
  localparam int VL_W   = $clog2(MAX_VL + 1);
  localparam int NREG   = 1 << REG_AW;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start_i = 1'b0;
  logic [VL_W-1:0]   vlen_i = '0;
  logic [REG_AW-1:0] dst_base_i = '0;
  logic [REG_AW-1:0] src_base_i = '0;
  logic [IMM_W-1:0]  imm_i = '0;
  logic              ff_en_i = 1'b0;
  logic              test_sel_i = 1'b0;
  logic              test_inv_i = 1'b0;
  logic              rf_rd_en_o;
  logic [REG_AW-1:0] rf_rd_addr_o;
  logic [DATA_W-1:0] rf_rd_data_i = '0;
  logic              rf_wr_en_o;
  logic [REG_AW-1:0] rf_wr_addr_o;
  logic [DATA_W-1:0] rf_wr_data_o;
  logic              done_o;
  logic [VL_W-1:0]   vlen_o;
  logic [MAX_VL-1:0] cond_bits_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rtot = 0;
  int wtot = 0;
  logic [DATA_W-1:0] mem  [NREG];
  logic [DATA_W-1:0] snap [NREG];
  logic [REG_AW-1:0] rdlog [4096];

  always #5 clk = ~clk;

  vloop_seq #(.DATA_W(DATA_W), .IMM_W(IMM_W), .REG_AW(REG_AW), .MAX_VL(MAX_VL)) u_vloop_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .vlen_i(vlen_i),
    .dst_base_i(dst_base_i), .src_base_i(src_base_i), .imm_i(imm_i),
    .ff_en_i(ff_en_i), .test_sel_i(test_sel_i), .test_inv_i(test_inv_i),
    .rf_rd_en_o(rf_rd_en_o), .rf_rd_addr_o(rf_rd_addr_o), .rf_rd_data_i(rf_rd_data_i),
    .rf_wr_en_o(rf_wr_en_o), .rf_wr_addr_o(rf_wr_addr_o), .rf_wr_data_o(rf_wr_data_o),
    .done_o(done_o), .vlen_o(vlen_o), .cond_bits_o(cond_bits_o)
  );

  // register file model: synchronous read, one cycle latency
  always @(posedge clk) begin
    if (rf_rd_en_o) begin
      rf_rd_data_i <= mem[rf_rd_addr_o];
      rdlog[rtot % 4096] <= rf_rd_addr_o;
      rtot <= rtot + 1;
    end
    if (rf_wr_en_o) begin
      mem[rf_wr_addr_o] <= rf_wr_data_o;
      wtot <= wtot + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual timeout expected loop completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_case(input string name, input int vl, input int dst, input int src,
                          input int imm, input bit ff, input bit sel, input bit inv,
                          input bit inject);
    int nreq, exp_vl, exp_w, exp_cyc, k, rbase, wbase, nrd;
    logic [MAX_VL-1:0] exp_cr;
    logic [DATA_W-1:0] expv [MAX_VL];
    logic [DATA_W-1:0] r;
    logic [DATA_W-1:0] simm;
    bit t, b;
    for (int a = 0; a < NREG; a++) snap[a] = mem[a];
    simm = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm[IMM_W-1:0]};
    nreq = (vl > MAX_VL) ? MAX_VL : vl;
    exp_vl = nreq; exp_w = nreq; exp_cr = '0;
    for (int i = 0; i < nreq; i++) begin
      r = snap[src + i] + simm;
      expv[i] = r;
      t = sel ? r[DATA_W-1] : (r == '0);
      b = t ^ inv;
      exp_cr[i] = b;
      if (ff && !b) begin
        exp_vl = i; exp_w = i + 1;
        break;
      end
    end
    if (nreq == 0) exp_cyc = 0;
    else if (exp_vl < nreq) exp_cyc = exp_vl + 2;
    else exp_cyc = nreq + 1;

    rbase = rtot; wbase = wtot;
    @(negedge clk);
    vlen_i = VL_W'(vl); dst_base_i = REG_AW'(dst); src_base_i = REG_AW'(src);
    imm_i = IMM_W'(imm); ff_en_i = ff; test_sel_i = sel; test_inv_i = inv;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    k = 0;
    while (!done_o && k < 100) begin
      @(negedge clk);
      k++;
      if (inject && k == 1) begin
        start_i = 1'b1; vlen_i = 3; dst_base_i = 0; src_base_i = 0; imm_i = 16'h7777;
        ff_en_i = 1'b1;
      end else if (inject && k == 2) begin
        start_i = 1'b0;
      end
    end
    start_i = 1'b0;
    chk(done_o == 1'b1, "R7", {name, " done seen"}, done_o, 1);
    chk(k == exp_cyc, (ff && exp_vl < nreq) ? "R4" : (nreq == 0 ? "R8" : "R1"),
        {name, " done latency"}, k, exp_cyc);
    chk(vlen_o == VL_W'(exp_vl), ff ? "R4" : "R6", {name, " final vl"}, vlen_o, exp_vl);
    chk(cond_bits_o == exp_cr, "R3", {name, " cond bits"}, cond_bits_o, exp_cr);
    chk((cond_bits_o >> vlen_o) == '0, "R9", {name, " tail bits"}, cond_bits_o >> vlen_o, 0);
    @(negedge clk);
    chk(done_o == 1'b0, "R7", {name, " done pulse width"}, done_o, 0);
    chk(wtot - wbase == exp_w, (nreq == 0) ? "R8" : "R5", {name, " write count"},
        wtot - wbase, exp_w);
    for (int i = 0; i < exp_w; i++)
      chk(mem[dst + i] == expv[i], "R2", {name, " write data"}, mem[dst + i], expv[i]);
    if (dst + exp_w < NREG)
      chk(mem[dst + exp_w] == snap[dst + exp_w], inject ? "R10" : "R4",
          {name, " register past end untouched"}, mem[dst + exp_w], snap[dst + exp_w]);
    nrd = rtot - rbase;
    chk(nrd >= exp_w && nrd <= nreq, "R1", {name, " read count"}, nrd, exp_w);
    for (int j = 0; j < exp_w; j++)
      chk(rdlog[(rbase + j) % 4096] == REG_AW'(src + j), "R1", {name, " read order"},
          rdlog[(rbase + j) % 4096], src + j);
  endtask

  task automatic t_ff_off_mixed();
    mem[8] = -3; mem[9] = 5; mem[10] = -3; mem[11] = 100; mem[12] = 0;
    run_case("R6 no-exit mixed", 5, 40, 8, 3, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_ff_zero_mid();
    for (int i = 0; i < 6; i++) mem[16 + i] = 0;
    mem[19] = 7;
    run_case("R4 exit mid zero test", 6, 48, 16, 0, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_ff_neg_first();
    mem[24] = 5; mem[25] = 100; mem[26] = 100; mem[27] = 100;
    run_case("R5 exit at element 0 neg imm", 4, 56, 24, 16'hFFF0, 1'b1, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_full_max();
    for (int i = 0; i < MAX_VL; i++) mem[32 + i] = i;
    run_case("R11 full max length", MAX_VL, 80, 32, 1, 1'b1, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_clamp();
    run_case("R11 over-length clamp", 20, 100, 32, -2, 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_zero_len();
    run_case("R8 zero length", 0, 20, 2, 1, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_busy_start();
    for (int i = 0; i < 8; i++) mem[i] = 10 * i;
    run_case("R10 start while busy", 8, 112, 0, 2, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_ff_last();
    mem[50] = 4; mem[51] = 5; mem[52] = -1;
    run_case("R4 exit at last element", 3, 60, 50, 1, 1'b1, 1'b0, 1'b1, 1'b0);
  endtask

  initial begin
    for (int a = 0; a < NREG; a++) mem[a] = DATA_W'(a * 3 + 1);
    repeat (3) @(negedge clk);
    chk(done_o == 1'b0, "R7", "reset done", done_o, 0);
    chk(rf_rd_en_o == 1'b0 && rf_wr_en_o == 1'b0, "R8", "reset strobes",
        {rf_rd_en_o, rf_wr_en_o}, 0);
    chk(vlen_o == '0 && cond_bits_o == '0, "R9", "reset results", cond_bits_o, 0);
    rst = 1'b0;
    @(negedge clk);
    t_ff_off_mixed();
    t_ff_zero_mid();
    t_ff_neg_first();
    t_full_max();
    t_clamp();
    t_zero_len();
    t_busy_start();
    t_ff_last();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule